// File: doc/BRIEF.md
# Recirculating Time-Compression Sample Memory

This block holds the most recent samples of a slowly sampled signal in a circular store. It plays them back again and again at a much higher word rate, so a later stage sees a time-compressed replica of the input once per revolution. By default the store holds 600 words of 6 bits. One word is read out every sixth cycle of the 12 MHz master clock, which gives a 2 MHz word rate and a revolution every 300 µs.

A sample arrives as a one-cycle strobe in the master clock domain and is held in a single-entry load buffer. It enters the store only at the loop tail, which is the last word slot of a revolution. There it replaces the oldest word. Each revolution therefore lists the newest samples oldest first, with the latest sample as the last word. Loading and unloading the buffer never overlap. A strobe that lands in the tail cycle holds the unload back until the next tail. A sample that replaces one still waiting in the buffer raises a sticky overflow flag.

Top module: `recirc_tc_mem`

## Requirements
- R1: After reset, word_o, word_stb_o, rev_start_o, pending_o and overflow_o are 0, and every stored word is 0.
- R2: word_stb_o is a one-cycle pulse that recurs every DIV master cycles (6 by default). word_o changes only together with it.
- R3: rev_start_o is high together with word_stb_o for word 0 of each revolution and for no other word. A revolution is DEPTH words (600 by default). The first word after reset is word 0.
- R4: While nothing is committed, every revolution plays back the same DEPTH words as the one before.
- R5: A cycle with sample_valid_i high latches sample_i into the load buffer, and pending_o is 1 from the next cycle.
- R6: A pending sample is committed at the tail step, which is the step that outputs word DEPTH-1. The revolution that follows starts with the old word 1 and ends with the new sample as word DEPTH-1, so the oldest word is dropped. pending_o then returns to 0.
- R7: If sample_valid_i is high while pending_o is 1, the newer sample replaces the buffered one and overflow_o becomes 1. overflow_o stays 1 until reset.
- R8: If sample_valid_i is high in the tail-step cycle, no commit takes place at that tail. The buffered sample is committed at the following tail instead.
- R9: Samples committed over successive revolutions appear oldest first, at the end of the playback order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| sample_i | input | WIDTH | incoming sample word |
| sample_valid_i | input | 1 | one-cycle strobe that qualifies sample_i |
| word_o | output | WIDTH | playback word stream |
| word_stb_o | output | 1 | pulse marking a new word_o |
| rev_start_o | output | 1 | pulse marking word 0 of a revolution |
| pending_o | output | 1 | a sample is waiting in the load buffer |
| overflow_o | output | 1 | sticky flag: a buffered sample was replaced before commit |

## Verification
The hardest case to reach from the ports is a sample strobe that lands in the single master cycle of the tail step while another sample is already waiting. The bench starts counting word strobes at a revolution marker and stops at word DEPTH-2. It then waits DIV-1 further cycles and drives the strobe into the cycle whose edge emits the last word. After that it captures two whole revolutions, which show first the blocked commit and then the deferred one.

// File: rtl/recirc_pkg.sv
package recirc_pkg;
  parameter int unsigned DEF_DEPTH = 600;
  parameter int unsigned DEF_WIDTH = 6;
  parameter int unsigned DEF_DIV   = 6;
endpackage

// File: rtl/recirc_step_gen.sv
module recirc_step_gen #(
  parameter int unsigned DIV = recirc_pkg::DEF_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign step_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2
  step_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
endmodule

// File: rtl/recirc_load_buf.sv
module recirc_load_buf #(
  parameter int unsigned WIDTH = recirc_pkg::DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sample_i,
  input  logic             valid_i,
  input  logic             tail_step_i,
  output logic [WIDTH-1:0] data_o,
  output logic             pending_o,
  output logic             overflow_o,
  output logic             commit_o
);
  // unload held off while a load is in flight
  assign commit_o = tail_step_i && pending_o && !valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o     <= '0;
      pending_o  <= 1'b0;
      overflow_o <= 1'b0;
    end else if (valid_i) begin
      data_o    <= sample_i;
      pending_o <= 1'b1;
      if (pending_o) overflow_o <= 1'b1;
    end else if (commit_o) begin
      pending_o <= 1'b0;
    end
  end

  // R5
  load_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> pending_o);
  // R7
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pending_o) |=> overflow_o);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

// File: rtl/recirc_loop.sv
module recirc_loop #(
  parameter int unsigned DEPTH = recirc_pkg::DEF_DEPTH,
  parameter int unsigned WIDTH = recirc_pkg::DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             tail_step_o,
  output logic [WIDTH-1:0] word_o,
  output logic             word_stb_o,
  output logic             rev_start_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    pos_q;
  logic [AW-1:0]    rd_addr_q;
  logic [AW-1:0]    wr_addr;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  assign tail_step_o = step_i && (pos_q == AW'(DEPTH - 1));
  // slot after the tail holds the oldest word
  assign wr_addr     = wrap_inc(rd_addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q       <= '0;
      rd_addr_q   <= '0;
      word_o      <= '0;
      word_stb_o  <= 1'b0;
      rev_start_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      word_stb_o  <= step_i;
      rev_start_o <= step_i && (pos_q == '0);
      if (step_i) begin
        word_o    <= mem_q[rd_addr_q];
        pos_q     <= wrap_inc(pos_q);
        rd_addr_q <= wr_en_i ? wrap_inc(wr_addr) : wr_addr;
        if (wr_en_i) mem_q[wr_addr] <= wr_data_i;
      end
    end
  end

  // R6
  tail_only_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> tail_step_o);
  // R3
  rev_on_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_start_o |-> word_stb_o);
  // R2
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |=> !word_stb_o);
  // R2
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_stb_o |-> $stable(word_o));
endmodule

// File: rtl/recirc_tc_mem.sv
module recirc_tc_mem #(
  parameter int unsigned DEPTH = recirc_pkg::DEF_DEPTH,
  parameter int unsigned WIDTH = recirc_pkg::DEF_WIDTH,
  parameter int unsigned DIV   = recirc_pkg::DEF_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sample_i,
  input  logic             sample_valid_i,
  output logic [WIDTH-1:0] word_o,
  output logic             word_stb_o,
  output logic             rev_start_o,
  output logic             pending_o,
  output logic             overflow_o
);
  logic             step;
  logic             tail_step;
  logic             commit;
  logic [WIDTH-1:0] buf_data;

  recirc_step_gen #(.DIV(DIV)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_o (step)
  );

  recirc_load_buf #(.WIDTH(WIDTH)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (sample_i),
    .valid_i     (sample_valid_i),
    .tail_step_i (tail_step),
    .data_o      (buf_data),
    .pending_o   (pending_o),
    .overflow_o  (overflow_o),
    .commit_o    (commit)
  );

  recirc_loop #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_loop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .wr_en_i     (commit),
    .wr_data_i   (buf_data),
    .tail_step_o (tail_step),
    .word_o      (word_o),
    .word_stb_o  (word_stb_o),
    .rev_start_o (rev_start_o)
  );

  // R8
  no_coincide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && tail_step) |=> pending_o);
endmodule

// File: tb/tb_recirc_tc_mem.sv
module tb_recirc_tc_mem;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 600;
  localparam int WIDTH = 6;
  localparam int DIV   = 6;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [WIDTH-1:0] sample_i = '0;
  logic             sample_valid_i = 1'b0;
  logic [WIDTH-1:0] word_o;
  logic             word_stb_o, rev_start_o, pending_o, overflow_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [WIDTH-1:0] cap [DEPTH];

  recirc_tc_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DIV(DIV)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
    .sample_valid_i(sample_valid_i), .word_o(word_o), .word_stb_o(word_stb_o),
    .rev_start_o(rev_start_o), .pending_o(pending_o), .overflow_o(overflow_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    sample_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic sync_rev();
    do @(negedge clk_i); while (!(word_stb_o && rev_start_o));
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk_i); while (!word_stb_o);
    end
  endtask

  task automatic pulse(input logic [WIDTH-1:0] v);
    sample_i = v;
    sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  // captures one whole revolution; returns R2/R3 error counts
  task automatic capture(output int gap_bad, output int rs_bad);
    int gap;
    gap_bad = 0;
    rs_bad = 0;
    sync_rev();
    cap[0] = word_o;
    for (int i = 1; i < DEPTH; i++) begin
      gap = 0;
      do begin @(negedge clk_i); gap++; end while (!word_stb_o);
      if (gap != DIV) gap_bad++;
      if (rev_start_o) rs_bad++;
      cap[i] = word_o;
    end
  endtask

  function automatic int nonzero_before(input int last);
    int n = 0;
    for (int i = 0; i < last; i++) if (cap[i] != '0) n++;
    return n;
  endfunction

  task automatic t_reset();
    int gb, rb, cyc;
    do_reset();
    check("R1 word_o", int'(word_o), 0);
    check("R1 pending_o", int'(pending_o), 0);
    check("R1 overflow_o", int'(overflow_o), 0);
    cyc = 0;
    do begin @(negedge clk_i); cyc++; end while (!word_stb_o);
    check("R3 first word is word 0", int'(rev_start_o), 1);
    check("R2 first strobe delay", cyc, DIV);
    capture(gb, rb);
    check("R2 strobe spacing", gb, 0);
    check("R3 single rev_start per rev", rb, 0);
    check("R1 R4 all stored zero", nonzero_before(DEPTH), 0);
  endtask

  task automatic t_commit();
    int gb, rb;
    do_reset();
    sync_rev();
    pulse(6'h2A);
    check("R5 pending after load", int'(pending_o), 1);
    capture(gb, rb);
    check("R6 new sample last word", int'(cap[DEPTH-1]), 'h2A);
    check("R6 others zero", nonzero_before(DEPTH-1), 0);
    check("R6 pending cleared", int'(pending_o), 0);
    capture(gb, rb);
    check("R4 contents recirculate", int'(cap[DEPTH-1]), 'h2A);
    check("R4 others still zero", nonzero_before(DEPTH-1), 0);
    check("R7 no overflow on single load", int'(overflow_o), 0);
  endtask

  task automatic t_overflow();
    int gb, rb;
    do_reset();
    sync_rev();
    pulse(6'h11);
    pulse(6'h22);
    check("R7 overflow set", int'(overflow_o), 1);
    capture(gb, rb);
    check("R7 newer sample kept", int'(cap[DEPTH-1]), 'h22);
    check("R7 older sample dropped", int'(cap[DEPTH-2]), 0);
    capture(gb, rb);
    check("R7 overflow sticky", int'(overflow_o), 1);
  endtask

  task automatic t_order();
    int gb, rb;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      sync_rev();
      pulse(WIDTH'(5 + i * 9));
    end
    capture(gb, rb);
    check("R9 oldest of three", int'(cap[DEPTH-3]), 5);
    check("R9 middle of three", int'(cap[DEPTH-2]), 14);
    check("R9 newest of three", int'(cap[DEPTH-1]), 23);
    check("R9 rest zero", nonzero_before(DEPTH-3), 0);
  endtask

  // strobe in the tail-step cycle, with and without a pending sample
  task automatic t_coincide(input bit preload);
    int gb, rb;
    do_reset();
    sync_rev();
    if (preload) pulse(6'h0F);
    wait_words(DEPTH - 2);
    repeat (DIV - 1) @(negedge clk_i);
    pulse(6'h33);
    check("R8 still pending after tail", int'(pending_o), 1);
    check("R7 overflow with preload", int'(overflow_o), int'(preload));
    capture(gb, rb);
    check("R8 commit blocked at tail", int'(cap[DEPTH-1]), 0);
    check("R8 pending cleared next tail", int'(pending_o), 0);
    capture(gb, rb);
    check("R8 committed at next tail", int'(cap[DEPTH-1]), 'h33);
    check("R8 single entry", int'(cap[DEPTH-2]), 0);
  endtask

  initial begin
    t_reset();
    t_commit();
    t_overflow();
    t_order();
    t_coincide(1'b0);
    t_coincide(1'b1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule